// File: doc/BRIEF.md
# Interpolation-Rate Clock Divider with Phase Restart

This block turns a fast sample clock into the slower data-rate timing used ahead of an interpolating datapath. The divide ratio follows a 2-bit interpolation code, giving ratios of 2, 4, 8 or 16 fast cycles. The block presents the divided waveform as a level with a 50% duty cycle, and it gives a one-cycle enable pulse at the start of every divided period. The level is the signal that goes out on a status pin when the device runs from a single external clock. The enable pulse is the one that on-chip logic uses.

Several devices can be aligned to each other with a phase strobe. When the sync option is on, the block passes a rising edge on the strobe through a two-flop synchronizer in the fast domain and then restarts its count from zero. Every device that sees the same strobe edge then starts its divided period on the same fast cycle. When the sync option is off, the block ignores the strobe. A new interpolation code takes effect only at the end of the current period or at a restart, so no short pulses appear.

Top module: `rate_divider`

## Requirements
- R1: While `rst` is high, `div_en` and `div_clk` are both 0. In the first cycle after the first rising edge with `rst` low, both outputs are 1.
- R2: The code on `ratio_sel` selects the period in fast cycles: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16. `div_en` pulses once per period, so consecutive pulses are that many cycles apart.
- R3: `div_clk` is high for the first half of each period and low for the second half. It rises only in a cycle in which `div_en` is also high.
- R4: `div_en` is high for exactly one cycle per period, and that cycle is the first cycle of the high half.
- R5: If `ratio_sel` changes in the middle of a period, that period still completes at the old length. The next period uses the new code.
- R6: With `sync_en` high, suppose `phase_strobe` goes from 0 to 1 and is first sampled high at rising edge E0. Then the count restarts at edge E2, and `div_en` and `div_clk` are both high in the cycle after E2.
- R7: With `sync_en` low, a strobe edge has no effect: the running period ends at its normal time.
- R8: A strobe held high causes only one restart. The periods after that restart have their normal length.
- R9: A restart also adopts the code on `ratio_sel` at that moment, so the period that starts at the restart already has the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sample clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | SEL_W (2) | Interpolation code, giving a ratio of 2^(code+1) |
| sync_en | input | 1 | Allows a strobe edge to restart the count |
| phase_strobe | input | 1 | External phase strobe, asynchronous to clk |
| div_en | output | 1 | One-cycle pulse at the start of each divided period |
| div_clk | output | 1 | Divided clock level with 50% duty cycle |

## Verification
The assertions assume three things about the inputs:
- `rst` is asserted at time zero.
- `sync_en` is stable around every edge at which a restart could occur. The check that a disabled sync never cuts a period short looks at the value of `sync_en` on the previous edge.
- Each strobe returns low for at least three fast cycles before it can rise again, so every edge that is meant to cause a restart is seen by the synchronizer.

The stimulus changes `phase_strobe`, `sync_en` and `ratio_sel` one time unit after a rising edge and never near an edge. Before it re-enables sync, it holds the strobe low for four cycles. It places every strobe edge at a known count, mid-way through the high half of a divide-by-16 period, so that a restart cannot be mistaken for a natural wrap.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   // log2 of the divide ratio for a given select code
   function automatic int unsigned ratio_log(input int unsigned code,
                                             input int unsigned min_log);
      return code + min_log;
   endfunction

   // last count value of a period for a given select code
   function automatic int unsigned last_count(input int unsigned code,
                                              input int unsigned min_log);
      return (32'd1 << ratio_log(code, min_log)) - 32'd1;
   endfunction

   typedef struct packed {
      logic wrap;
      logic restart;
   } cnt_evt_t;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe_in,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("strobe_sync: STAGES must be at least 2");
   end

   // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous level
   logic [STAGES:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain[0] <= 1'b0;
      else     chain[0] <= strobe_in;
   end

   for (genvar s = 1; s <= STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) chain[s] <= 1'b0;
         else     chain[s] <= chain[s-1];
      end
   end

   assign rise_o = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/div_counter.sv
module div_counter
   import clkdiv_pkg::*;
#(
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned MIN_LOG = 1,
   localparam int unsigned CODES  = 1 << SEL_W,
   localparam int unsigned CNT_W  = CODES - 1 + MIN_LOG
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel_in,
   output logic [CNT_W-1:0] cnt_o,
   output logic [SEL_W-1:0] act_o
);

   logic [CNT_W-1:0] term_tab [CODES];

   for (genvar c = 0; c < CODES; c++) begin : g_term
      localparam int unsigned TV = last_count(c, MIN_LOG);
      assign term_tab[c] = TV[CNT_W-1:0];
   end

   logic [CNT_W-1:0] cnt_q;
   logic [SEL_W-1:0] act_q;
   cnt_evt_t         evt;

   assign evt.restart = restart;
   assign evt.wrap    = (cnt_q == term_tab[act_q]);

   always_ff @(posedge clk) begin
      if (rst) begin
         // park on the last count so outputs stay low until release
         act_q <= sel_in;
         cnt_q <= term_tab[sel_in];
      end else if (evt.restart || evt.wrap) begin
         act_q <= sel_in;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign act_o = act_q;

endmodule

// File: rtl/div_outstage.sv
module div_outstage #(
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned MIN_LOG = 1,
   localparam int unsigned CODES  = 1 << SEL_W,
   localparam int unsigned CNT_W  = CODES - 1 + MIN_LOG
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [SEL_W-1:0] act_i,
   output logic             en_o,
   output logic             lvl_o
);

   // high half: the bit worth half the ratio is still clear
   logic [CODES-1:0] hi_vec;

   for (genvar c = 0; c < CODES; c++) begin : g_half
      assign hi_vec[c] = ~cnt_i[c + MIN_LOG - 1];
   end

   assign lvl_o = hi_vec[act_i];
   assign en_o  = (cnt_i == '0);

endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
   parameter int unsigned SEL_W       = 2,
   parameter int unsigned MIN_LOG     = 1,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CODES      = 1 << SEL_W,
   localparam int unsigned CNT_W      = CODES - 1 + MIN_LOG
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] ratio_sel,
   input  logic             sync_en,
   input  logic             phase_strobe,
   output logic             div_en,
   output logic             div_clk
);

   if (MIN_LOG < 1) begin : g_bad_minlog
      $error("rate_divider: MIN_LOG must be at least 1 for an even ratio");
   end
   if (SEL_W < 1 || CNT_W > 24) begin : g_bad_sel
      $error("rate_divider: SEL_W out of range");
   end

   logic             strobe_rise;
   logic             restart;
   logic [CNT_W-1:0] cnt;
   logic [SEL_W-1:0] act_sel;

   strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst       (rst),
      .strobe_in (phase_strobe),
      .rise_o    (strobe_rise)
   );

   assign restart = sync_en & strobe_rise;

   div_counter #(.SEL_W(SEL_W), .MIN_LOG(MIN_LOG)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .sel_in  (ratio_sel),
      .cnt_o   (cnt),
      .act_o   (act_sel)
   );

   div_outstage #(.SEL_W(SEL_W), .MIN_LOG(MIN_LOG)) u_out (
      .cnt_i (cnt),
      .act_i (act_sel),
      .en_o  (div_en),
      .lvl_o (div_clk)
   );

endmodule

// File: rtl/rate_divider_chk.sv
module rate_divider_chk #(
   parameter int unsigned MAX_PERIOD = 16
) (
   input logic clk,
   input logic rst,
   input logic sync_en,
   input logic div_en,
   input logic div_clk
);

   logic       past_valid;
   logic       seen_en;
   logic [7:0] gap;

   always_ff @(posedge clk) begin
      past_valid <= 1'b1;
      if (rst) begin
         seen_en <= 1'b0;
         gap     <= '0;
      end else if (div_en) begin
         seen_en <= 1'b1;
         gap     <= 8'd1;
      end else if (gap != 8'hFF) begin
         gap     <= gap + 8'd1;
      end
   end

   // R1: outputs quiet after any reset edge
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> (!div_en && !div_clk));

   // R4: the enable pulse falls inside the high half
   p_en_in_high_r4: assert property (@(posedge clk) disable iff (rst)
      div_en |-> div_clk);

   // R3: the level rises only at the start of a period
   p_rise_with_en_r3: assert property (@(posedge clk) disable iff (rst)
      (past_valid && $rose(div_clk)) |-> div_en);

   // R2: no period is longer than the largest ratio
   p_period_bound_r2: assert property (@(posedge clk) disable iff (rst)
      (div_en && seen_en) |-> (gap <= 8'(MAX_PERIOD)));

   // R7: with sync off, a period starts only after the low half
   p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
      (past_valid && div_en && !$past(sync_en) && !$past(rst)) |-> !$past(div_clk));

endmodule

bind rate_divider rate_divider_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .sync_en (sync_en),
   .div_en  (div_en),
   .div_clk (div_clk)
);

// File: tb/tb_rate_divider.sv
`timescale 1ns/1ps
module tb_rate_divider;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] ratio_sel = 2'd2;
   logic       sync_en = 1'b0;
   logic       phase_strobe = 1'b0;
   logic       div_en;
   logic       div_clk;

   int vectors = 0;
   int errs = 0;

   always #2 clk = ~clk;

   rate_divider dut (
      .clk          (clk),
      .rst          (rst),
      .ratio_sel    (ratio_sel),
      .sync_en      (sync_en),
      .phase_strobe (phase_strobe),
      .div_en       (div_en),
      .div_clk      (div_clk)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_en(output int n);
      n = 0;
      do begin
         tick();
         n++;
      end while (!div_en && n < 100);
   endtask

   task automatic t_reset();
      int n;
      rst = 1'b1;
      ratio_sel = 2'd2;
      repeat (3) tick();
      check(div_en == 1'b0, "R1 en in reset", div_en, 0);
      check(div_clk == 1'b0, "R1 clk in reset", div_clk, 0);
      rst = 1'b0;
      tick();
      check(div_en == 1'b1, "R1 en after release", div_en, 1);
      check(div_clk == 1'b1, "R1 clk after release", div_clk, 1);
      wait_en(n);
      check(n == 8, "R1 first period", n, 8);
   endtask

   task automatic t_ratio(input int code);
      int n, period, hi, ratio;
      ratio = 2 << code;
      ratio_sel = 2'(code);
      wait_en(n);
      wait_en(n);
      check(div_clk == 1'b1, "R4 en in high half", div_clk, 1);
      hi = 1;
      period = 0;
      do begin
         tick();
         period++;
         if (!div_en && div_clk) hi++;
      end while (!div_en && period < 40);
      check(period == ratio, "R2 period", period, ratio);
      check(hi == ratio / 2, "R3 high cycles", hi, ratio / 2);
   endtask

   task automatic t_sel_change();
      int n;
      ratio_sel = 2'd3;
      wait_en(n);
      wait_en(n);
      repeat (3) tick();
      ratio_sel = 2'd0;
      wait_en(n);
      check(n == 13, "R5 old period completes", n, 13);
      wait_en(n);
      check(n == 2, "R5 new period", n, 2);
   endtask

   task automatic t_sync();
      int n;
      ratio_sel = 2'd3;
      sync_en = 1'b1;
      wait_en(n);
      wait_en(n);
      repeat (5) tick();
      phase_strobe = 1'b1;
      tick();
      check(div_en == 1'b0 && div_clk == 1'b1, "R6 no restart at E0", div_en, 0);
      tick();
      check(div_en == 1'b0, "R6 no restart at E1", div_en, 0);
      tick();
      check(div_en == 1'b1 && div_clk == 1'b1, "R6 restart at E2", div_en, 1);
      wait_en(n);
      check(n == 16, "R8 held strobe no second restart", n, 16);
      phase_strobe = 1'b0;
      wait_en(n);
      check(n == 16, "R8 period after release", n, 16);
   endtask

   task automatic t_sync_off();
      int n;
      sync_en = 1'b0;
      ratio_sel = 2'd3;
      wait_en(n);
      wait_en(n);
      repeat (5) tick();
      phase_strobe = 1'b1;
      wait_en(n);
      check(n == 11, "R7 strobe ignored", n, 11);
      phase_strobe = 1'b0;
      repeat (4) tick();
   endtask

   task automatic t_restart_sel();
      int n;
      sync_en = 1'b1;
      ratio_sel = 2'd3;
      wait_en(n);
      wait_en(n);
      repeat (5) tick();
      ratio_sel = 2'd1;
      phase_strobe = 1'b1;
      repeat (3) tick();
      check(div_en == 1'b1, "R9 restart fires", div_en, 1);
      wait_en(n);
      check(n == 4, "R9 new ratio at restart", n, 4);
      phase_strobe = 1'b0;
      wait_en(n);
      check(n == 4, "R9 ratio kept", n, 4);
      sync_en = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      errs++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

   initial begin
      t_reset();
      for (int c = 0; c < 4; c++) t_ratio(c);
      t_ratio(1);
      t_sel_change();
      t_sync();
      repeat (4) tick();
      t_sync_off();
      t_restart_sel();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

endmodule